// File: doc/BRIEF.md
# Thirty-Two Step Pulse-Width Modulator with Power-Down

This block generates a pulse-width modulated output from a five-bit duty code. A free-running counter steps once per tick-enable pulse and wraps every 32 ticks. The output is high while the counter is below the live duty code. Duty can therefore be set from zero up to 31/32 of the period, in steps of 1/32.

A separate full-on setting drives the output high for the whole period, which gives a true 100%. A power-down command releases the output: the enable drops so the pin can be tri-stated, and the counter freezes. A recall command resumes operation from the start of a fresh period.

Commands arrive as single-cycle strobes from an upstream decoder. There is no valid/ready handshake. Every strobe is accepted in the cycle it is high, so there is no back-pressure, and a strobe cannot be stalled or lost. New duty and full-on settings are first held as pending. They go live only at a period boundary, or at a recall, so a pulse is never cut or stretched partway through.

Top module: `pwm5_gen`

## Requirements
- R1: After reset the output enable is 1, the output is 0, the live duty is 0, full-on is off, and the block is running (not powered down).
- R2: The counter advances by one only in cycles where `tick_en` is 1, and wraps from 31 to 0. While `tick_en` is 0 the output holds its value. With full-on off, the output is high exactly while the counter is below the live duty code.
- R3: A duty code of 0 with full-on off gives an output that is low for the whole period.
- R4: A duty code of 31 gives 31 high ticks and 1 low tick in each 32-tick period.
- R5: A duty code or full-on setting goes live only when the counter wraps, or at a recall. The remainder of the current period keeps the old setting.
- R6: When full-on is live and the block is running, the output is high on every tick.
- R7: A duty strobe stores the code and clears full-on. If duty and full-on strobes arrive in the same cycle, full-on ends up set.
- R8: A power-down strobe makes `pwm_oe` 0 and `pwm_out` 0 from the next cycle. The counter then stays frozen. Duty and full-on strobes received while powered down are still stored.
- R9: A recall strobe while powered down sets `pwm_oe` to 1 in the next cycle, restarts the counter at 0, and makes the stored settings live at once.
- R10: A recall strobe while running has no effect. The counter continues without restarting.
- R11: If power-down and recall strobes arrive in the same cycle, power-down wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable, one tick per high cycle |
| set_duty_stb | input | 1 | Strobe: store `duty_in` and clear full-on |
| duty_in | input | 5 | Duty code, high ticks per 32 |
| full_on_stb | input | 1 | Strobe: request a 100% output |
| shutdown_stb | input | 1 | Strobe: power down and release the output |
| recall_stb | input | 1 | Strobe: leave power-down and restart the period |
| pwm_out | output | 1 | Modulated output, 0 while released |
| pwm_oe | output | 1 | Output enable for the tri-state pad driver |

## Verification
Every result depends only on registers, so each output change appears one clock after the edge that captures the strobe or the tick. A power-down or recall is therefore visible in the first sample after its capturing edge. A new duty becomes visible only after the next wrap, which is at most 32 ticks away. The bench drives and samples on the falling edge. After a recall it counts samples from the known counter value 0, so each check can predict the exact cycle where a pulse starts and ends. Duty settings are checked by counting high samples over a full 32-tick window taken after the update is certain to be live.

// File: rtl/pwm5_pkg.sv
`timescale 1ns/1ps
package pwm5_pkg;
  localparam int unsigned PWM5_DUTY_W = 5;

  typedef enum logic {
    PWR_RUN  = 1'b0,
    PWR_HALT = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/pwm5_power.sv
`timescale 1ns/1ps
// Power-down state machine: power-down wins over recall, recall restarts.
module pwm5_power
  import pwm5_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shutdown_stb,
  input  logic recall_stb,
  output logic halted,
  output logic restart
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_RUN:  if (shutdown_stb) state_d = PWR_HALT;
      PWR_HALT: if (recall_stb && !shutdown_stb) state_d = PWR_RUN;
      default:  state_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PWR_RUN;
    else        state_q <= state_d;
  end

  assign halted  = (state_q == PWR_HALT);
  assign restart = halted && recall_stb && !shutdown_stb;
endmodule

// File: rtl/pwm5_counter.sv
`timescale 1ns/1ps
// Period counter: ticks while running, clears on restart.
module pwm5_counter #(
  parameter int unsigned DUTY_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              halted,
  input  logic              restart,
  output logic [DUTY_W-1:0] cnt,
  output logic              wrap
);
  localparam logic [DUTY_W-1:0] CNT_TOP = {DUTY_W{1'b1}};

  logic advance;
  assign advance = tick_en && !halted;
  assign wrap    = advance && (cnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (advance) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm5_setting.sv
`timescale 1ns/1ps
// Pending and live settings; the live copy changes only at a boundary.
module pwm5_setting #(
  parameter int unsigned DUTY_W     = 5,
  parameter bit          AT_BOUNDARY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_duty_stb,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              full_on_stb,
  input  logic              boundary,
  output logic [DUTY_W-1:0] live_duty,
  output logic              live_fo
);
  logic [DUTY_W-1:0] pend_duty;
  logic              pend_fo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_duty <= '0;
      pend_fo   <= 1'b0;
    end else begin
      if (set_duty_stb) begin
        pend_duty <= duty_in;
        pend_fo   <= 1'b0;
      end
      if (full_on_stb) pend_fo <= 1'b1;
    end
  end

  generate
    if (AT_BOUNDARY) begin : g_deferred
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          live_duty <= '0;
          live_fo   <= 1'b0;
        end else if (boundary) begin
          live_duty <= pend_duty;
          live_fo   <= pend_fo;
        end
      end
    end else begin : g_direct
      assign live_duty = pend_duty;
      assign live_fo   = pend_fo;
    end
  endgenerate
endmodule

// File: rtl/pwm5_gen.sv
`timescale 1ns/1ps
// Top: 32-step PWM with full-on and power-down.
module pwm5_gen
  import pwm5_pkg::*;
#(
  parameter int unsigned DUTY_W = PWM5_DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              set_duty_stb,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              full_on_stb,
  input  logic              shutdown_stb,
  input  logic              recall_stb,
  output logic              pwm_out,
  output logic              pwm_oe
);
  logic              halted;
  logic              restart;
  logic [DUTY_W-1:0] cnt;
  logic              wrap;
  logic [DUTY_W-1:0] live_duty;
  logic              live_fo;
  logic              below;

  pwm5_power u_power (
    .clk(clk), .rst_n(rst_n),
    .shutdown_stb(shutdown_stb), .recall_stb(recall_stb),
    .halted(halted), .restart(restart)
  );

  pwm5_counter #(.DUTY_W(DUTY_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .halted(halted), .restart(restart),
    .cnt(cnt), .wrap(wrap)
  );

  pwm5_setting #(.DUTY_W(DUTY_W), .AT_BOUNDARY(1'b1)) u_setting (
    .clk(clk), .rst_n(rst_n),
    .set_duty_stb(set_duty_stb), .duty_in(duty_in),
    .full_on_stb(full_on_stb), .boundary(wrap || restart),
    .live_duty(live_duty), .live_fo(live_fo)
  );

  assign below   = (cnt < live_duty);
  assign pwm_oe  = !halted;
  assign pwm_out = !halted && (live_fo || below);
endmodule

// File: rtl/pwm5_gen_chk.sv
`timescale 1ns/1ps
module pwm5_gen_chk #(
  parameter int unsigned DUTY_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shutdown_stb,
  input logic              recall_stb,
  input logic              halted,
  input logic              restart,
  input logic              wrap,
  input logic [DUTY_W-1:0] cnt,
  input logic [DUTY_W-1:0] live_duty,
  input logic              live_fo,
  input logic              pwm_out,
  input logic              pwm_oe
);
  assert_released_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_oe |-> !pwm_out);
  assert_shutdown_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_stb |=> !pwm_oe);
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> $stable(cnt));
  assert_full_on_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe && live_fo) |-> pwm_out);
  assert_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe && !live_fo && live_duty == '0) |-> !pwm_out);
  assert_live_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !restart) |=> ($stable(live_duty) && $stable(live_fo)));
  assert_recall_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pwm_oe && cnt == '0));
  assert_recall_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_stb && !halted && !shutdown_stb) |=> pwm_oe);
  assert_collision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_stb && recall_stb) |=> !pwm_oe);
endmodule

bind pwm5_gen pwm5_gen_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .shutdown_stb(shutdown_stb), .recall_stb(recall_stb),
  .halted(halted), .restart(restart), .wrap(wrap), .cnt(cnt),
  .live_duty(live_duty), .live_fo(live_fo),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/pwm5_gen_test.sv
`timescale 1ns/1ps
module pwm5_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       set_duty_stb = 1'b0;
  logic [4:0] duty_in = '0;
  logic       full_on_stb = 1'b0;
  logic       shutdown_stb = 1'b0;
  logic       recall_stb = 1'b0;
  logic       pwm_out;
  logic       pwm_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm5_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .set_duty_stb(set_duty_stb), .duty_in(duty_in),
    .full_on_stb(full_on_stb), .shutdown_stb(shutdown_stb),
    .recall_stb(recall_stb), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_duty(input logic [4:0] d);
    duty_in = d; set_duty_stb = 1'b1; cyc(); set_duty_stb = 1'b0;
  endtask
  task automatic pulse_full();
    full_on_stb = 1'b1; cyc(); full_on_stb = 1'b0;
  endtask
  task automatic pulse_down();
    shutdown_stb = 1'b1; cyc(); shutdown_stb = 1'b0;
  endtask
  task automatic pulse_recall();
    recall_stb = 1'b1; cyc(); recall_stb = 1'b0;
  endtask

  // Leaves the bench at the first sample after recall, counter at 0.
  task automatic restart_with(input logic [4:0] d);
    pulse_duty(d); pulse_down(); pulse_recall();
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (pwm_out) hi++;
    end
  endtask

  task automatic test_reset();
    int hi;
    chk(pwm_oe == 1'b1, "R1 oe after reset", pwm_oe, 1);
    chk(pwm_out == 1'b0, "R1 out after reset", pwm_out, 0);
    count_high(32, hi);
    chk(hi == 0, "R3 zero duty high ticks", hi, 0);
  endtask

  task automatic test_duty_levels();
    int hi, run;
    bit ended;
    restart_with(5'd31);
    hi = pwm_out ? 1 : 0;
    for (int i = 1; i < 32; i++) begin cyc(); if (pwm_out) hi++; end
    chk(hi == 31, "R4 max code high ticks", hi, 31);
    cyc();
    chk(pwm_out == 1'b1, "R4 wraps high again", pwm_out, 1);
    restart_with(5'd13);
    run = 0; ended = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i > 0) cyc();
      if (pwm_out && !ended) run++;
      else ended = 1'b1;
    end
    chk(run == 13, "R2 first run length", run, 13);
  endtask

  task automatic test_boundary();
    int hi1 = 0, hi2 = 0;
    bit first33 = 1'b0;
    restart_with(5'd8);
    if (pwm_out) hi1++;
    for (int s = 2; s <= 64; s++) begin
      if (s == 3) begin duty_in = 5'd20; set_duty_stb = 1'b1; end
      cyc();
      set_duty_stb = 1'b0;
      if (s <= 32) begin if (pwm_out) hi1++; end
      else begin
        if (pwm_out) hi2++;
        if (s == 33) first33 = pwm_out;
      end
    end
    chk(hi1 == 8, "R5 old duty rest of period", hi1, 8);
    chk(hi2 == 20, "R5 new duty next period", hi2, 20);
    chk(first33 == 1'b1, "R5 new period starts high", first33, 1);
  endtask

  task automatic test_full_on();
    int hi;
    pulse_full();
    repeat (33) cyc();
    count_high(32, hi);
    chk(hi == 32, "R6 full-on high ticks", hi, 32);
    pulse_duty(5'd10);
    repeat (33) cyc();
    count_high(32, hi);
    chk(hi == 10, "R7 duty clears full-on", hi, 10);
    duty_in = 5'd4; set_duty_stb = 1'b1; full_on_stb = 1'b1;
    cyc();
    set_duty_stb = 1'b0; full_on_stb = 1'b0;
    repeat (33) cyc();
    count_high(32, hi);
    chk(hi == 32, "R7 same-cycle full-on wins", hi, 32);
  endtask

  task automatic test_shutdown();
    int oe_seen = 0, out_seen = 0, run = 0;
    bit ended = 1'b0;
    pulse_down();
    chk(pwm_oe == 1'b0, "R8 oe off next cycle", pwm_oe, 0);
    chk(pwm_out == 1'b0, "R8 out low when off", pwm_out, 0);
    pulse_duty(5'd5);
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (pwm_oe) oe_seen++;
      if (pwm_out) out_seen++;
    end
    chk(oe_seen == 0, "R8 stays released", oe_seen, 0);
    chk(out_seen == 0, "R8 stays low", out_seen, 0);
    pulse_recall();
    chk(pwm_oe == 1'b1, "R9 oe back after recall", pwm_oe, 1);
    for (int i = 0; i < 32; i++) begin
      if (i > 0) cyc();
      if (pwm_out && !ended) run++;
      else ended = 1'b1;
    end
    chk(run == 5, "R9 stored duty from counter zero", run, 5);
  endtask

  task automatic test_recall_idle();
    restart_with(5'd8);
    repeat (3) cyc();
    pulse_recall();
    repeat (3) cyc();
    chk(pwm_out == 1'b1, "R10 still high at tick 7", pwm_out, 1);
    cyc();
    chk(pwm_out == 1'b0, "R10 no restart, low at tick 8", pwm_out, 0);
  endtask

  task automatic test_collision();
    shutdown_stb = 1'b1; recall_stb = 1'b1;
    cyc();
    shutdown_stb = 1'b0; recall_stb = 1'b0;
    chk(pwm_oe == 1'b0, "R11 power-down wins", pwm_oe, 0);
    pulse_recall();
    chk(pwm_oe == 1'b1, "R11 recall recovers", pwm_oe, 1);
  endtask

  task automatic test_tick_gate();
    int hi = 0;
    restart_with(5'd3);
    repeat (2) cyc();
    tick_en = 1'b0;
    for (int i = 0; i < 10; i++) begin cyc(); if (pwm_out) hi++; end
    chk(hi == 10, "R2 output holds without ticks", hi, 10);
    tick_en = 1'b1;
    cyc();
    chk(pwm_out == 1'b0, "R2 resumes at next tick", pwm_out, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) cyc();
    rst_n = 1'b1;
    cyc();
    test_reset();
    test_duty_levels();
    test_boundary();
    test_full_on();
    test_shutdown();
    test_recall_idle();
    test_collision();
    test_tick_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule